// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical address by reading up to four 64-bit translation entries from memory, one level at a time. A walk begins with the frame number of the top-level table, given on a root input. At each level nine bits of the virtual address pick an entry in the current table. A present entry either names the next table or, at the two middle levels, maps a large page directly. The walker performs one memory transaction at a time. It reads each entry over a valid/ready read port. When an upper-level entry has its accessed flag clear, it writes that entry back with the flag set over a separate write port.

The walker also gathers the access rights along the way. The user and writable rights are the AND over every entry read. Execution is forbidden if any entry sets its no-execute bit. The walker checks reserved bits at every level. A walk ends with a one-cycle `done` pulse. With that pulse come either a fault indication, which tells a not-present fault apart from a reserved-bit fault, or the physical address, a page-size code, the combined rights, and the final entry together with its address. The permission decision, caching of results and nested translation belong to the requester.

Top module: `pt_walker4`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `done`, `rd_valid` and `wr_valid` are 0.
- R2: The table-entry address for each level is {table frame, 9-bit index, 3'b000}. The index comes from virtual-address bits [47:39], [38:30], [29:21] and [20:12], in that order. The first frame is `root_pfn`, and each later frame is bits [PA_W-1:12] of the previous entry.
- R3: An entry with bit 0 (present) clear ends the walk at once with `fault`=1 and `fault_rsvd`=0, and no further read or write is issued.
- R4: A top-level entry with bit 7 (page size) set ends the walk with a reserved-bit fault (`fault`=1, `fault_rsvd`=1).
- R5: At any level, a present entry with a bit in [51:PA_W] set gives a reserved-bit fault. When `nx_enable` is 0, bit 63 set also gives a reserved-bit fault.
- R6: Bit 7 set on the third-level entry ends the walk with a 1 GB page: `out_size`=2 and `out_paddr`={entry[PA_W-1:30], va[29:0]}. Bit 7 set on the second-level entry gives a 2 MB page: `out_size`=1 and `out_paddr`={entry[PA_W-1:21], va[20:0]}. Otherwise the fourth entry gives a 4 KB page: `out_size`=0 and `out_paddr`={entry[PA_W-1:12], va[11:0]}.
- R7: A large-page entry with any bit set in [29:13] (1 GB) or [20:13] (2 MB) gives a reserved-bit fault, and no write-back is made for it. Bit 12 of a large-page entry is ignored.
- R8: When bit 5 (accessed) is clear in a non-faulting top-level or third-level entry, or in a second-level entry that points to a table, the walker writes the entry with bit 5 set back to the address it was read from. It does this before the next read or completion. A 4 KB leaf entry and a 2 MB leaf entry are never written.
- R9: `out_user` is the AND of bit 2 and `out_write` is the AND of bit 1 over all entries read. `out_nx` is the OR of bit 63 over those entries.
- R10: `done` is high for exactly one cycle per walk. With it, `out_leaf` is the final entry as read and `out_leaf_addr` is the address of that entry.
- R11: At most one of `req_ready`, `rd_valid` and `wr_valid` is high in any cycle. A read request that is not accepted holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nx_enable | input | 1 | No-execute bit in use; when 0, bit 63 is reserved |
| root_pfn | input | PA_W-12 | Frame number of the top-level table |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, accepts a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rd_valid | output | 1 | Entry read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | PA_W | Entry read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 64 | Entry read from memory |
| wr_valid | output | 1 | Accessed-flag write-back request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | PA_W | Write-back address |
| wr_data | output | 64 | Entry with accessed flag set |
| done | output | 1 | One-cycle walk completion |
| fault | output | 1 | Walk failed (valid with done) |
| fault_rsvd | output | 1 | Failure was a reserved-bit fault |
| out_paddr | output | PA_W | Translated physical address |
| out_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| out_user | output | 1 | Combined user right |
| out_write | output | 1 | Combined write right |
| out_nx | output | 1 | Combined no-execute |
| out_leaf | output | 64 | Final entry as read |
| out_leaf_addr | output | PA_W | Address of final entry |

## Verification
The bench builds small page tables in a memory model and runs walks that end at each of the three page sizes. A mix-up between the level that may map a 1 GB page and the level that may map a 2 MB page would show as a wrong size code or a wrong count of reads. It also places the accessed flag, the no-execute bit and the user and write bits on different levels. A design that wrote back leaf entries, skipped a write-back, or kept only the last level's rights would leave wrong memory contents or wrong rights. The bench also targets the fault paths: a missing entry, a page-size bit at the top, a high physical bit, no-execute while it is disabled, and misaligned large pages. For these it checks that a design which checked too late, or wrote back before faulting, issues extra transactions.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WB      = 2'd3
    } walk_st_e;

    // entry bit positions
    localparam int BIT_P       = 0;
    localparam int BIT_RW      = 1;
    localparam int BIT_US      = 2;
    localparam int BIT_A       = 5;
    localparam int BIT_PS      = 7;
    localparam int BIT_PAT     = 12;
    localparam int BIT_NX      = 63;
    localparam int ENT_ADDR_HI = 51;

    // geometry
    localparam int PG_SHIFT = 12;
    localparam int IDX_W    = 9;
    localparam int MD_SHIFT = PG_SHIFT + IDX_W;
    localparam int LG_SHIFT = MD_SHIFT + IDX_W;

    // level numbering: 3 = top, 0 = final table
    localparam logic [1:0] LVL_TOP = 2'd3;
    localparam logic [1:0] LVL_1G  = 2'd2;
    localparam logic [1:0] LVL_2M  = 2'd1;
    localparam logic [1:0] LVL_4K  = 2'd0;

    localparam logic [1:0] SZ_4K = 2'd0;
    localparam logic [1:0] SZ_2M = 2'd1;
    localparam logic [1:0] SZ_1G = 2'd2;

endpackage

// File: rtl/pt_table_addr.sv
module pt_table_addr
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 40,
    parameter int VA_W = 48
) (
    input  logic [PA_W-PG_SHIFT-1:0] base_pfn,
    input  logic [VA_W-1:PG_SHIFT]   va_hi,
    input  logic [1:0]               level,
    output logic [PA_W-1:0]          addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        case (level)
            LVL_TOP: idx = va_hi[LG_SHIFT+IDX_W +: IDX_W];
            LVL_1G:  idx = va_hi[LG_SHIFT +: IDX_W];
            LVL_2M:  idx = va_hi[MD_SHIFT +: IDX_W];
            default: idx = va_hi[PG_SHIFT +: IDX_W];
        endcase
        addr = {base_pfn, idx, 3'b000};
    end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [63:0] entry,
    input  logic [1:0]  level,
    input  logic        nx_enable,
    output logic        present,
    output logic        rsvd,
    output logic        is_leaf,
    output logic        need_wb,
    output logic [1:0]  size
);
    logic [63:0] rmask;
    logic        ps;
    logic        misalign;

    always_comb begin
        rmask = '0;
        for (int b = PA_W; b <= ENT_ADDR_HI; b++) begin
            rmask[b] = 1'b1;
        end
        rmask[BIT_NX] = ~nx_enable;

        ps       = entry[BIT_PS];
        present  = entry[BIT_P];
        is_leaf  = 1'b0;
        size     = SZ_4K;
        misalign = 1'b0;

        case (level)
            LVL_TOP: begin
                is_leaf = 1'b0;
            end
            LVL_1G: begin
                if (ps) begin
                    is_leaf  = 1'b1;
                    size     = SZ_1G;
                    misalign = |entry[LG_SHIFT-1:BIT_PAT+1];
                end
            end
            LVL_2M: begin
                if (ps) begin
                    is_leaf  = 1'b1;
                    size     = SZ_2M;
                    misalign = |entry[MD_SHIFT-1:BIT_PAT+1];
                end
            end
            default: begin
                is_leaf = 1'b1;
            end
        endcase

        rsvd    = (|(entry & rmask)) | ((level == LVL_TOP) & ps) | misalign;
        need_wb = ~entry[BIT_A] &
                  ((level == LVL_TOP) | (level == LVL_1G) | ((level == LVL_2M) & ~ps));
    end

endmodule

// File: rtl/pt_leaf_paddr.sv
module pt_leaf_paddr
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [PA_W-PG_SHIFT-1:0] leaf_pfn,
    input  logic [LG_SHIFT-1:0]      va_lo,
    input  logic [1:0]               size,
    output logic [PA_W-1:0]          paddr
);
    logic [PA_W-1:0] frame;

    always_comb begin
        frame = {leaf_pfn, {PG_SHIFT{1'b0}}};
        case (size)
            SZ_1G:   paddr = {frame[PA_W-1:LG_SHIFT], va_lo[LG_SHIFT-1:0]};
            SZ_2M:   paddr = {frame[PA_W-1:MD_SHIFT], va_lo[MD_SHIFT-1:0]};
            default: paddr = {frame[PA_W-1:PG_SHIFT], va_lo[PG_SHIFT-1:0]};
        endcase
    end

endmodule

// File: rtl/pt_walker4.sv
module pt_walker4
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 40,
    parameter int VA_W = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     nx_enable,
    input  logic [PA_W-PG_SHIFT-1:0] root_pfn,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_vaddr,
    output logic                     rd_valid,
    input  logic                     rd_ready,
    output logic [PA_W-1:0]          rd_addr,
    input  logic                     rd_resp_valid,
    input  logic [63:0]              rd_resp_data,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output logic [PA_W-1:0]          wr_addr,
    output logic [63:0]              wr_data,
    output logic                     done,
    output logic                     fault,
    output logic                     fault_rsvd,
    output logic [PA_W-1:0]          out_paddr,
    output logic [1:0]               out_size,
    output logic                     out_user,
    output logic                     out_write,
    output logic                     out_nx,
    output logic [63:0]              out_leaf,
    output logic [PA_W-1:0]          out_leaf_addr
);
    localparam int PFN_W = PA_W - PG_SHIFT;

    typedef struct packed {
        walk_st_e         st;
        logic [1:0]       lvl;
        logic [VA_W-1:0]  va;
        logic [PFN_W-1:0] base;
        logic             user;
        logic             wr;
        logic             xok;
        logic [63:0]      ent;
        logic [PA_W-1:0]  ent_addr;
        logic             leaf;
        logic [1:0]       size;
        logic             done;
        logic             fault;
        logic             fault_rsvd;
        logic [PA_W-1:0]  paddr;
    } regs_t;

    regs_t q, d;

    logic [PA_W-1:0]  tbl_addr;
    logic             ev_present, ev_rsvd, ev_leaf, ev_wb;
    logic [1:0]       ev_size;
    logic [PFN_W-1:0] pa_pfn;
    logic [1:0]       pa_size;
    logic [PA_W-1:0]  pa_out;
    logic             in_wait;

    assign in_wait = (q.st == ST_RD_WAIT);
    assign pa_pfn  = in_wait ? rd_resp_data[PA_W-1:PG_SHIFT] : q.ent[PA_W-1:PG_SHIFT];
    assign pa_size = in_wait ? ev_size : q.size;

    pt_table_addr #(.PA_W(PA_W), .VA_W(VA_W)) i_addr (
        .base_pfn (q.base),
        .va_hi    (q.va[VA_W-1:PG_SHIFT]),
        .level    (q.lvl),
        .addr     (tbl_addr)
    );

    pt_entry_eval #(.PA_W(PA_W)) i_eval (
        .entry     (rd_resp_data),
        .level     (q.lvl),
        .nx_enable (nx_enable),
        .present   (ev_present),
        .rsvd      (ev_rsvd),
        .is_leaf   (ev_leaf),
        .need_wb   (ev_wb),
        .size      (ev_size)
    );

    pt_leaf_paddr #(.PA_W(PA_W)) i_paddr (
        .leaf_pfn (pa_pfn),
        .va_lo    (q.va[LG_SHIFT-1:0]),
        .size     (pa_size),
        .paddr    (pa_out)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st         = ST_RD_REQ;
                    d.lvl        = LVL_TOP;
                    d.va         = req_vaddr;
                    d.base       = root_pfn;
                    d.user       = 1'b1;
                    d.wr         = 1'b1;
                    d.xok        = 1'b1;
                    d.fault      = 1'b0;
                    d.fault_rsvd = 1'b0;
                end
            end
            ST_RD_REQ: begin
                if (rd_ready) begin
                    d.st       = ST_RD_WAIT;
                    d.ent_addr = tbl_addr;
                end
            end
            ST_RD_WAIT: begin
                if (rd_resp_valid) begin
                    d.ent = rd_resp_data;
                    if (!ev_present || ev_rsvd) begin
                        d.st         = ST_IDLE;
                        d.done       = 1'b1;
                        d.fault      = 1'b1;
                        d.fault_rsvd = ev_present;
                    end else begin
                        d.user = q.user & rd_resp_data[BIT_US];
                        d.wr   = q.wr & rd_resp_data[BIT_RW];
                        d.xok  = q.xok & ~rd_resp_data[BIT_NX];
                        d.leaf = ev_leaf;
                        d.size = ev_size;
                        if (ev_wb) begin
                            d.st = ST_WB;
                        end else if (ev_leaf) begin
                            d.st    = ST_IDLE;
                            d.done  = 1'b1;
                            d.paddr = pa_out;
                        end else begin
                            d.st   = ST_RD_REQ;
                            d.lvl  = q.lvl - 2'd1;
                            d.base = rd_resp_data[PA_W-1:PG_SHIFT];
                        end
                    end
                end
            end
            ST_WB: begin
                if (wr_ready) begin
                    if (q.leaf) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.paddr = pa_out;
                    end else begin
                        d.st   = ST_RD_REQ;
                        d.lvl  = q.lvl - 2'd1;
                        d.base = q.ent[PA_W-1:PG_SHIFT];
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rd_valid      = (q.st == ST_RD_REQ);
    assign rd_addr       = tbl_addr;
    assign wr_valid      = (q.st == ST_WB);
    assign wr_addr       = q.ent_addr;
    assign wr_data       = q.ent | (64'd1 << BIT_A);
    assign done          = q.done;
    assign fault         = q.fault;
    assign fault_rsvd    = q.fault_rsvd;
    assign out_paddr     = q.paddr;
    assign out_size      = q.size;
    assign out_user      = q.user;
    assign out_write     = q.wr;
    assign out_nx        = ~q.xok;
    assign out_leaf      = q.ent;
    assign out_leaf_addr = q.ent_addr;

endmodule

// File: rtl/pt_walker4_chk.sv
module pt_walker4_chk #(
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [PA_W-1:0] rd_addr,
    input logic            rd_resp_valid,
    input logic            wr_valid,
    input logic [63:0]     wr_data,
    input logic            done,
    input logic            fault,
    input logic [1:0]      out_size
);

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, rd_valid, wr_valid}));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_wb_abit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[5]);

    assert_wb_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(rd_resp_valid));

    assert_size_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> out_size != 2'd3);

endmodule

bind pt_walker4 pt_walker4_chk #(.PA_W(PA_W)) i_pt_walker4_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_addr       (rd_addr),
    .rd_resp_valid (rd_resp_valid),
    .wr_valid      (wr_valid),
    .wr_data       (wr_data),
    .done          (done),
    .fault         (fault),
    .out_size      (out_size)
);

// File: tb/test_pt_walker4.sv
`timescale 1ns/1ps
module test_pt_walker4;
    localparam int PA_W = 40;
    localparam int VA_W = 48;

    localparam logic [63:0] F_P  = 64'h1;
    localparam logic [63:0] F_RW = 64'h2;
    localparam logic [63:0] F_US = 64'h4;
    localparam logic [63:0] F_A  = 64'h20;
    localparam logic [63:0] F_PS = 64'h80;
    localparam logic [63:0] F_NX = 64'h8000_0000_0000_0000;
    localparam logic [63:0] UP   = F_P | F_RW | F_US;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             nx_enable = 1'b1;
    logic [PA_W-13:0] root_pfn = 28'h1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             rd_valid;
    logic             rd_ready = 1'b1;
    logic [PA_W-1:0]  rd_addr;
    logic             rd_resp_valid = 1'b0;
    logic [63:0]      rd_resp_data = '0;
    logic             wr_valid;
    logic             wr_ready = 1'b1;
    logic [PA_W-1:0]  wr_addr;
    logic [63:0]      wr_data;
    logic             done, fault, fault_rsvd;
    logic [PA_W-1:0]  out_paddr;
    logic [1:0]       out_size;
    logic             out_user, out_write, out_nx;
    logic [63:0]      out_leaf;
    logic [PA_W-1:0]  out_leaf_addr;

    always #5 clk = ~clk;

    pt_walker4 #(.PA_W(PA_W), .VA_W(VA_W)) i_pt_walker4 (
        .clk(clk), .rst_n(rst_n), .nx_enable(nx_enable), .root_pfn(root_pfn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .fault(fault), .fault_rsvd(fault_rsvd), .out_paddr(out_paddr),
        .out_size(out_size), .out_user(out_user), .out_write(out_write), .out_nx(out_nx),
        .out_leaf(out_leaf), .out_leaf_addr(out_leaf_addr)
    );

    logic [63:0] mem [logic [PA_W-1:0]];
    int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0, overlap = 0;
    logic        r_fault, r_rsvd, r_user, r_write, r_nx, r_after;
    logic [1:0]  r_size;
    logic [63:0] r_paddr, r_leaf, r_leaf_addr;

    function automatic logic [63:0] mk(input logic [63:0] pa, input logic [63:0] fl);
        return (pa & 64'h0000_00FF_FFFF_F000) | fl;
    endfunction

    function automatic logic [47:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                         input logic [8:0] c, input logic [8:0] e,
                                         input logic [11:0] off);
        return {a, b, c, e, off};
    endfunction

    function automatic logic [63:0] rdm(input logic [PA_W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // memory model: read answered one cycle after acceptance
    initial begin
        logic [PA_W-1:0] a;
        forever begin
            @(negedge clk);
            rd_resp_valid = 1'b0;
            if (rd_valid) begin
                a = rd_addr;
                @(negedge clk);
                rd_resp_valid = 1'b1;
                rd_resp_data  = rdm(a);
                rd_cnt++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (wr_valid) begin
                mem[wr_addr] = wr_data;
                wr_cnt++;
            end
            if (rst_n && (int'(req_ready) + int'(rd_valid) + int'(wr_valid) > 1)) overlap++;
        end
    end

    task automatic walk(input logic [47:0] va);
        logic got;
        got = 1'b0;
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk);
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !got; i++) begin
            if (done) begin
                got = 1'b1;
                r_fault = fault; r_rsvd = fault_rsvd; r_size = out_size;
                r_user = out_user; r_write = out_write; r_nx = out_nx;
                r_paddr = 64'(out_paddr); r_leaf = out_leaf;
                r_leaf_addr = 64'(out_leaf_addr);
            end else begin
                @(negedge clk);
            end
        end
        chk("R10 done seen", 64'(got), 64'd1);
        @(negedge clk);
        r_after = done;
    endtask

    task automatic t_reset;
        chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 rd_valid in reset", 64'(rd_valid), 64'd0);
        chk("R1 wr_valid in reset", 64'(wr_valid), 64'd0);
    endtask

    task automatic t_4k;
        mem.delete();
        mem[40'h1008] = mk(64'h2000, UP | F_A);
        mem[40'h2010] = mk(64'h3000, UP);
        mem[40'h3018] = mk(64'h4000, UP | F_A);
        mem[40'h4020] = mk(64'hABCDE000, UP);
        walk(mkva(9'd1, 9'd2, 9'd3, 9'd4, 12'h123));
        chk("R3 no fault 4K", 64'(r_fault), 64'd0);
        chk("R6 4K size", 64'(r_size), 64'd0);
        chk("R6 R2 4K paddr", r_paddr, 64'hABCDE123);
        chk("R2 reads 4K", 64'(rd_cnt), 64'd4);
        chk("R8 one write-back", 64'(wr_cnt), 64'd1);
        chk("R8 level3 A set", rdm(40'h2010), mk(64'h3000, UP | F_A));
        chk("R8 leaf untouched", rdm(40'h4020), mk(64'hABCDE000, UP));
        chk("R10 leaf value", r_leaf, mk(64'hABCDE000, UP));
        chk("R10 leaf addr", r_leaf_addr, 64'h4020);
        chk("R10 done one cycle", 64'(r_after), 64'd0);
        chk("R9 rights all set", {61'd0, r_user, r_write, r_nx}, 64'b110);
    endtask

    task automatic t_rights;
        nx_enable = 1'b1;
        mem.delete();
        mem[40'h1000] = mk(64'h2000, UP | F_A);
        mem[40'h2000] = mk(64'h3000, F_P | F_US | F_A);
        mem[40'h3000] = mk(64'h4000, F_P | F_RW | F_A);
        mem[40'h4000] = mk(64'h5000, UP | F_NX);
        walk(mkva(9'd0, 9'd0, 9'd0, 9'd0, 12'h004));
        chk("R9 rights mixed", {61'd0, r_user, r_write, r_nx}, 64'b001);
        chk("R9 paddr", r_paddr, 64'h5004);
        mem[40'h1000] = mk(64'h2000, UP | F_A | F_NX);
        mem[40'h2000] = mk(64'h3000, UP | F_A);
        mem[40'h3000] = mk(64'h4000, UP | F_A);
        mem[40'h4000] = mk(64'h5000, UP);
        walk(mkva(9'd0, 9'd0, 9'd0, 9'd0, 12'h004));
        chk("R9 nx from top only", {61'd0, r_user, r_write, r_nx}, 64'b111);
    endtask

    task automatic t_1g;
        logic [47:0] va;
        mem.delete();
        va = mkva(9'd2, 9'd5, 9'h1AB, 9'h0CD, 12'h321);
        mem[40'h1010] = mk(64'h2000, UP);
        mem[40'h2028] = mk(64'h80000000, UP | F_PS);
        walk(va);
        chk("R6 1G size", 64'(r_size), 64'd2);
        chk("R6 1G paddr", r_paddr, 64'h80000000 | 64'(va[29:0]));
        chk("R6 1G reads", 64'(rd_cnt), 64'd2);
        chk("R8 1G write-backs", 64'(wr_cnt), 64'd2);
        chk("R8 top A set", rdm(40'h1010), mk(64'h2000, UP | F_A));
        chk("R8 1G entry A set", rdm(40'h2028), mk(64'h80000000, UP | F_PS | F_A));
        chk("R10 1G leaf as read", r_leaf, mk(64'h80000000, UP | F_PS));
    endtask

    task automatic t_2m;
        logic [47:0] va;
        mem.delete();
        va = mkva(9'd0, 9'd1, 9'd2, 9'h055, 12'h777);
        mem[40'h1000] = mk(64'h2000, UP | F_A);
        mem[40'h2008] = mk(64'h3000, UP | F_A);
        mem[40'h3010] = mk(64'h00600000, UP | F_PS) | (64'd1 << 12);
        walk(va);
        chk("R7 PAT bit ignored", 64'(r_fault), 64'd0);
        chk("R6 2M size", 64'(r_size), 64'd1);
        chk("R6 2M paddr", r_paddr, 64'h00600000 | 64'(va[20:0]));
        chk("R6 2M reads", 64'(rd_cnt), 64'd3);
        chk("R8 2M leaf not written", 64'(wr_cnt), 64'd0);
    endtask

    task automatic t_notpresent;
        mem.delete();
        mem[40'h1000] = mk(64'h2000, UP | F_A);
        walk(48'd0);
        chk("R3 fault", {62'd0, r_fault, r_rsvd}, 64'b10);
        chk("R3 reads stop", 64'(rd_cnt), 64'd2);
        chk("R3 no write", 64'(wr_cnt), 64'd0);
        mem[40'h1000] = mk(64'h2000, F_RW | F_US);
        walk(48'd0);
        chk("R3 top not present", {62'd0, r_fault, r_rsvd}, 64'b10);
        chk("R3 top reads", 64'(rd_cnt), 64'd1);
    endtask

    task automatic t_rsvd;
        mem.delete();
        mem[40'h1000] = mk(64'h2000, UP | F_PS);
        walk(48'd0);
        chk("R4 top PS fault", {62'd0, r_fault, r_rsvd}, 64'b11);
        chk("R4 reads", 64'(rd_cnt), 64'd1);
        mem[40'h1000] = mk(64'h2000, UP | F_A);
        mem[40'h2000] = mk(64'h3000, UP | F_A);
        mem[40'h3000] = mk(64'h4000, UP | F_A);
        mem[40'h4000] = mk(64'h5000, UP) | (64'd1 << 45);
        walk(48'd0);
        chk("R5 high PA bit fault", {62'd0, r_fault, r_rsvd}, 64'b11);
        chk("R5 reads", 64'(rd_cnt), 64'd4);
        nx_enable = 1'b0;
        mem[40'h4000] = mk(64'h5000, UP);
        mem[40'h3000] = mk(64'h4000, UP | F_A | F_NX);
        walk(48'd0);
        chk("R5 NX reserved", {62'd0, r_fault, r_rsvd}, 64'b11);
        chk("R5 NX reads", 64'(rd_cnt), 64'd3);
        nx_enable = 1'b1;
    endtask

    task automatic t_align;
        mem.delete();
        mem[40'h1000] = mk(64'h2000, UP | F_A);
        mem[40'h2000] = mk(64'h80100000, UP | F_PS);
        walk(48'd0);
        chk("R7 1G misaligned", {62'd0, r_fault, r_rsvd}, 64'b11);
        chk("R7 no write-back", 64'(wr_cnt), 64'd0);
        mem[40'h2000] = mk(64'h3000, UP | F_A);
        mem[40'h3000] = mk(64'h00602000, UP | F_PS | F_A);
        walk(48'd0);
        chk("R7 2M misaligned", {62'd0, r_fault, r_rsvd}, 64'b11);
        chk("R7 2M reads", 64'(rd_cnt), 64'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_4k();
        t_rights();
        t_1g();
        t_2m();
        t_notpresent();
        t_rsvd();
        t_align();
        chk("R11 one transaction at a time", 64'(overlap), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule